// File: doc/BRIEF.md
# T1 Transmit Channel Override Multiplexer

This block sits in the transmit path of a T1 framer. The frame is serial and 193 bits long: one framing bit, then 24 channels of 8 bits each. For every bit time the block decides where the outgoing bit comes from. There are four sources:

- the backplane serial input;
- one idle code shared by all channels;
- a code of the channel's own;
- the bit recovered by the receive-side framer, which gives per-channel loopback.

It also drives a per-bit channel index and a per-channel transparency flag. A later stage uses the flag to decide whether robbed-bit signaling and bit-7 stuffing may be applied on top of the channel.

Software programs the block through a plain write port (address, data, strobe). Every write lands in a shadow copy. The working copy picks it up at the next channel boundary, so no channel is ever sent half with old settings and half with new. One mode bit sets what the three idle masks mean: either idle-code insertion or loopback selection. A separate mask, together with 24 code registers, places a different code into each flagged channel.

Top module: `t1_chan_override`

## Requirements
- R1: The bit position follows the frame. A high `fsync` marks the framing bit (position 0). Positions then advance by one per clock and wrap from 192 to 0. Channel n occupies positions 8(n-1)+1 to 8n. Each output shows the bit time that was presented one clock earlier. `tx_chan` is 0 for the framing bit and n for channel n.
- R2: During the framing bit, `tx_bit` copies `bp_bit` no matter how the block is configured, and `tx_transp` is 0.
- R3: Each 24-channel mask is spread over three byte addresses. Data bit b of the first byte is channel b+1, of the second byte channel b+9, and of the third byte channel b+17. The idle masks are at 0x00 to 0x02, the unique-code masks at 0x05 to 0x07, and the transparency masks at 0x08 to 0x0A.
- R4: With the mode bit at 0, a channel whose idle-mask bit is 1 sends the idle code held at 0x03. Code bit 7 goes out in the channel's first bit time and code bit 0 in its last.
- R5: With the mode bit at 1 (address 0x04, data bit 0), a channel whose idle-mask bit is 1 sends `rx_bit`, and a channel whose idle-mask bit is 0 uses the remaining rules.
- R6: A channel whose unique-code mask bit is 1 sends the code at address 0x10+(n-1), MSB first.
- R7: The sources rank as follows: loopback first, then unique code, then idle code, then backplane.
- R8: `tx_transp` equals the channel's transparency-mask bit during all eight of its bit times.
- R9: A write changes the shadow copy at once. The change reaches the output only for channels that start after the write, counting the framing bit as a boundary.
- R10: After reset all masks and the mode bit are 0, so the backplane passes through, and the idle code is 0x7F. The outputs are 0 while reset is held.
- R11: Writes to addresses outside the map have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 8 | Register write data |
| fsync | input | 1 | High in the framing-bit time |
| bp_bit | input | 1 | Backplane serial data |
| rx_bit | input | 1 | Receive-side framer serial data |
| tx_bit | output | 1 | Outgoing serial bit |
| tx_chan | output | 5 | Channel of `tx_bit` (0 = framing bit) |
| tx_transp | output | 1 | Channel is marked transparent |

## Verification
Each output is registered, so its value for a bit time is due one clock after that bit time's inputs are sampled. A register write affects only channels that begin after the next boundary, which can be up to eight clocks after the write. The bench model folds both delays into its bookkeeping: on each rising edge it computes the expected outputs from the settings in force at that moment, and only then applies pending shadow copies and writes. The comparison against the design is made on the following falling edge, once the registered outputs have settled.

// File: rtl/t1ovr_pkg.sv
package t1ovr_pkg;
  // register map (word addresses)
  localparam int ADDR_IDLE_MASK = 'h00;
  localparam int ADDR_IDLE_CODE = 'h03;
  localparam int ADDR_MODE      = 'h04;
  localparam int ADDR_UC_MASK   = 'h05;
  localparam int ADDR_TR_MASK   = 'h08;
  localparam int ADDR_UC_BASE   = 'h10;

  // channel number (1-based) of a frame position, 0 for the framing bit
  function automatic int unsigned chan_of(input int unsigned pos, input int unsigned cw);
    if (pos == 0) return 0;
    return (pos - 1) / cw + 1;
  endfunction

  // code bit index sent at a frame position (MSB first)
  function automatic int unsigned codebit_of(input int unsigned pos, input int unsigned cw);
    if (pos == 0) return 0;
    return cw - 1 - ((pos - 1) % cw);
  endfunction

  // position is the framing bit or the last bit of a channel
  function automatic bit last_of_slot(input int unsigned pos, input int unsigned cw);
    return (pos % cw) == 0;
  endfunction
endpackage

// File: rtl/t1ovr_timing.sv
module t1ovr_timing
  import t1ovr_pkg::*;
#(
  parameter int NCH = 24,
  parameter int CW  = 8,
  localparam int FRAME_BITS = NCH * CW + 1,
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic [CNT_W-1:0] pos,
  output logic             slot_end
);
  localparam int LAST = FRAME_BITS - 1;

  logic [CNT_W-1:0] cnt_q;

  assign pos      = fsync ? '0 : cnt_q;
  assign slot_end = last_of_slot(32'(pos), CW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (pos == CNT_W'(LAST))  cnt_q <= '0;
    else                           cnt_q <= pos + 1'b1;
  end

  // R1: counter stays inside the frame and steps by one
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LAST));
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && cnt_q < CNT_W'(LAST)) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_cnt_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && cnt_q == CNT_W'(LAST)) |=> cnt_q == '0);
  p_sync_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> cnt_q == CNT_W'(1));
endmodule

// File: rtl/t1ovr_regs.sv
module t1ovr_regs
  import t1ovr_pkg::*;
#(
  parameter int NCH      = 24,
  parameter int CW       = 8,
  parameter int AW       = 6,
  parameter int IDLE_RST = 'h7F,
  localparam int NGRP = NCH / CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic              load,
  output logic [NCH-1:0]    act_idle_mask,
  output logic [CW-1:0]     act_idle_code,
  output logic              act_mode,
  output logic [NCH-1:0]    act_uc_mask,
  output logic [NCH-1:0]    act_tr_mask,
  output logic [NCH*CW-1:0] act_uc_codes
);
  logic [NCH-1:0]    sh_idle_mask, sh_uc_mask, sh_tr_mask;
  logic [CW-1:0]     sh_idle_code;
  logic              sh_mode;
  logic [NCH*CW-1:0] sh_uc_codes;

  // shadow copy: written at once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_idle_mask <= '0;
      sh_uc_mask   <= '0;
      sh_tr_mask   <= '0;
      sh_idle_code <= CW'(IDLE_RST);
      sh_mode      <= 1'b0;
      sh_uc_codes  <= '0;
    end else if (wr_en) begin
      for (int g = 0; g < NGRP; g++) begin
        if (wr_addr == AW'(ADDR_IDLE_MASK + g)) sh_idle_mask[g*CW +: CW] <= wr_data;
        if (wr_addr == AW'(ADDR_UC_MASK + g))   sh_uc_mask[g*CW +: CW]   <= wr_data;
        if (wr_addr == AW'(ADDR_TR_MASK + g))   sh_tr_mask[g*CW +: CW]   <= wr_data;
      end
      if (wr_addr == AW'(ADDR_IDLE_CODE)) sh_idle_code <= wr_data;
      if (wr_addr == AW'(ADDR_MODE))      sh_mode      <= wr_data[0];
      for (int c = 0; c < NCH; c++) begin
        if (wr_addr == AW'(ADDR_UC_BASE + c)) sh_uc_codes[c*CW +: CW] <= wr_data;
      end
    end
  end

  // working copy: follows the shadow only at a channel boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_idle_mask <= '0;
      act_uc_mask   <= '0;
      act_tr_mask   <= '0;
      act_idle_code <= CW'(IDLE_RST);
      act_mode      <= 1'b0;
      act_uc_codes  <= '0;
    end else if (load) begin
      act_idle_mask <= sh_idle_mask;
      act_uc_mask   <= sh_uc_mask;
      act_tr_mask   <= sh_tr_mask;
      act_idle_code <= sh_idle_code;
      act_mode      <= sh_mode;
      act_uc_codes  <= sh_uc_codes;
    end
  end

  // R9: the working copy never moves inside a channel
  p_hold_in_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_idle_mask) && $stable(act_uc_mask) && $stable(act_tr_mask)
               && $stable(act_idle_code) && $stable(act_mode) && $stable(act_uc_codes)));
  p_take_shadow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (act_idle_code == $past(sh_idle_code) && act_mode == $past(sh_mode)));
endmodule

// File: rtl/t1ovr_select.sv
module t1ovr_select
  import t1ovr_pkg::*;
#(
  parameter int NCH = 24,
  parameter int CW  = 8,
  localparam int FRAME_BITS = NCH * CW + 1,
  localparam int CNT_W = $clog2(FRAME_BITS),
  localparam int CH_W  = $clog2(NCH + 1),
  localparam int CI_W  = $clog2(NCH),
  localparam int BS_W  = $clog2(CW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  pos,
  input  logic              bp_bit,
  input  logic              rx_bit,
  input  logic [NCH-1:0]    idle_mask,
  input  logic [CW-1:0]     idle_code,
  input  logic              mode,
  input  logic [NCH-1:0]    uc_mask,
  input  logic [NCH-1:0]    tr_mask,
  input  logic [NCH*CW-1:0] uc_codes,
  output logic              tx_bit,
  output logic [CH_W-1:0]   tx_chan,
  output logic              tx_transp
);
  int unsigned     chan_num;
  logic            is_frame;
  logic [CI_W-1:0] ci;
  logic [BS_W-1:0] bsel;
  logic [NCH-1:0]  uc_bit_vec;
  logic            sel_loop, sel_uc, sel_idle;
  logic            nxt_bit, nxt_tr;

  assign chan_num = chan_of(32'(pos), CW);
  assign is_frame = (chan_num == 0);
  assign ci       = is_frame ? '0 : CI_W'(chan_num - 1);
  assign bsel     = BS_W'(codebit_of(32'(pos), CW));

  // current code bit of every channel's unique code
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [CW-1:0] code_c;
    assign code_c        = uc_codes[c*CW +: CW];
    assign uc_bit_vec[c] = code_c[bsel];
  end

  // priority: loopback, unique code, idle code, backplane
  assign sel_loop = !is_frame && mode && idle_mask[ci];
  assign sel_uc   = !is_frame && !sel_loop && uc_mask[ci];
  assign sel_idle = !is_frame && !sel_loop && !sel_uc && !mode && idle_mask[ci];

  always_comb begin
    if (sel_loop)      nxt_bit = rx_bit;
    else if (sel_uc)   nxt_bit = uc_bit_vec[ci];
    else if (sel_idle) nxt_bit = idle_code[bsel];
    else               nxt_bit = bp_bit;
  end
  assign nxt_tr = !is_frame && tr_mask[ci];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_bit    <= 1'b0;
      tx_chan   <= '0;
      tx_transp <= 1'b0;
    end else begin
      tx_bit    <= nxt_bit;
      tx_chan   <= CH_W'(chan_num);
      tx_transp <= nxt_tr;
    end
  end

  // R5: a loopback slot carries the receive bit
  p_loop_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_loop |=> tx_bit == $past(rx_bit));
  // R6: a unique-code slot carries its own code bit
  p_uc_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_uc |=> tx_bit == $past(uc_bit_vec[ci]));
  // R8: no transparency flag on the framing bit
  p_transp_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_chan == '0) |-> !tx_transp);
endmodule

// File: rtl/t1_chan_override.sv
module t1_chan_override #(
  parameter int NCH      = 24,
  parameter int CW       = 8,
  parameter int AW       = 6,
  parameter int IDLE_RST = 'h7F,
  localparam int FRAME_BITS = NCH * CW + 1,
  localparam int CNT_W = $clog2(FRAME_BITS),
  localparam int CH_W  = $clog2(NCH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [CW-1:0]   wr_data,
  input  logic            fsync,
  input  logic            bp_bit,
  input  logic            rx_bit,
  output logic            tx_bit,
  output logic [CH_W-1:0] tx_chan,
  output logic            tx_transp
);
  logic [CNT_W-1:0]  pos;
  logic              slot_end;
  logic [NCH-1:0]    a_idle_mask, a_uc_mask, a_tr_mask;
  logic [CW-1:0]     a_idle_code;
  logic              a_mode;
  logic [NCH*CW-1:0] a_uc_codes;

  t1ovr_timing #(.NCH(NCH), .CW(CW)) u_timing (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .pos(pos), .slot_end(slot_end));

  t1ovr_regs #(.NCH(NCH), .CW(CW), .AW(AW), .IDLE_RST(IDLE_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(slot_end), .act_idle_mask(a_idle_mask), .act_idle_code(a_idle_code),
    .act_mode(a_mode), .act_uc_mask(a_uc_mask), .act_tr_mask(a_tr_mask),
    .act_uc_codes(a_uc_codes));

  t1ovr_select #(.NCH(NCH), .CW(CW)) u_select (
    .clk(clk), .rst_n(rst_n), .pos(pos), .bp_bit(bp_bit), .rx_bit(rx_bit),
    .idle_mask(a_idle_mask), .idle_code(a_idle_code), .mode(a_mode),
    .uc_mask(a_uc_mask), .tr_mask(a_tr_mask), .uc_codes(a_uc_codes),
    .tx_bit(tx_bit), .tx_chan(tx_chan), .tx_transp(tx_transp));

  // R2: the framing bit passes the backplane bit
  p_frame_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (tx_bit == $past(bp_bit) && tx_chan == '0 && !tx_transp));
  // R1: channel index stays in range
  p_chan_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_chan <= CH_W'(NCH));
endmodule

// File: tb/sim_t1_chan_override.sv
`timescale 1ns/1ps
module sim_t1_chan_override;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       fsync = 1'b0;
  logic       bp_bit = 1'b0;
  logic       rx_bit = 1'b0;
  logic       tx_bit;
  logic [4:0] tx_chan;
  logic       tx_transp;

  always #4 clk = ~clk;  // 125 MHz

  t1_chan_override u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fsync(fsync), .bp_bit(bp_bit), .rx_bit(rx_bit),
    .tx_bit(tx_bit), .tx_chan(tx_chan), .tx_transp(tx_transp));

  int total = 0;
  int bad = 0;
  string cur_req = "R10";
  bit chk_en = 0;
  int fcnt = 0;

  // behavioural reference state
  bit sh_idle[1:24], sh_uc[1:24], sh_tr[1:24];
  bit ac_idle[1:24], ac_uc[1:24], ac_tr[1:24];
  int sh_code[1:24], ac_code[1:24];
  int sh_icode, ac_icode;
  bit sh_mode, ac_mode;
  int mpos;
  bit exp_bit;
  int exp_chan;
  bit exp_tr;

  task automatic model_reset();
    for (int n = 1; n <= 24; n++) begin
      sh_idle[n] = 0; sh_uc[n] = 0; sh_tr[n] = 0; sh_code[n] = 0;
      ac_idle[n] = 0; ac_uc[n] = 0; ac_tr[n] = 0; ac_code[n] = 0;
    end
    sh_icode = 'h7F; ac_icode = 'h7F; sh_mode = 0; ac_mode = 0;
    mpos = 0; exp_bit = 0; exp_chan = 0; exp_tr = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int p, ch, b;
      p = fsync ? 0 : mpos;
      if (p == 0) begin
        exp_chan = 0; exp_bit = bp_bit; exp_tr = 0;
      end else begin
        ch = (p - 1) / 8 + 1;
        b = 7 - ((p - 1) % 8);
        exp_chan = ch;
        exp_tr = ac_tr[ch];
        if (ac_mode && ac_idle[ch])       exp_bit = rx_bit;
        else if (ac_uc[ch])               exp_bit = ac_code[ch][b];
        else if (!ac_mode && ac_idle[ch]) exp_bit = ac_icode[b];
        else                              exp_bit = bp_bit;
      end
      if (p % 8 == 0) begin
        ac_idle = sh_idle; ac_uc = sh_uc; ac_tr = sh_tr; ac_code = sh_code;
        ac_icode = sh_icode; ac_mode = sh_mode;
      end
      if (wr_en) begin
        int a;
        a = int'(wr_addr);
        for (int k = 0; k < 8; k++) begin
          if (a <= 2)           sh_idle[a * 8 + k + 1] = wr_data[k];
          if (a >= 5 && a <= 7) sh_uc[(a - 5) * 8 + k + 1] = wr_data[k];
          if (a >= 8 && a <= 10) sh_tr[(a - 8) * 8 + k + 1] = wr_data[k];
        end
        if (a == 3) sh_icode = int'(wr_data);
        if (a == 4) sh_mode = wr_data[0];
        if (a >= 16 && a <= 39) sh_code[a - 15] = int'(wr_data);
      end
      mpos = (p == 192) ? 0 : p + 1;
    end
  end

  // compare on the falling edge, after the registered outputs settle
  always @(negedge clk) begin
    if (chk_en) begin
      total++;
      if (tx_bit !== exp_bit || int'(tx_chan) != exp_chan || tx_transp !== exp_tr) begin
        bad++;
        $display("FAIL %s: bit=%0d chan=%0d tr=%0d exp bit=%0d chan=%0d tr=%0d",
                 cur_req, tx_bit, tx_chan, tx_transp, exp_bit, exp_chan, exp_tr);
      end
    end
  end

  task automatic step(input bit we, input int addr, input int data);
    @(negedge clk);
    fsync   = (fcnt == 0);
    fcnt    = (fcnt == 192) ? 0 : fcnt + 1;
    bp_bit  = 1'($urandom_range(0, 1));
    rx_bit  = 1'($urandom_range(0, 1));
    wr_en   = we;
    wr_addr = 6'(addr);
    wr_data = 8'(data);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic wr(input int addr, input int data);
    step(1, addr, data);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R10: outputs held at zero in reset
    total++;
    if (tx_bit !== 1'b0 || tx_chan !== 5'd0 || tx_transp !== 1'b0) begin
      bad++;
      $display("FAIL R10: reset outputs bit=%0d chan=%0d tr=%0d exp 0 0 0",
               tx_bit, tx_chan, tx_transp);
    end
    @(negedge clk);
    rst_n = 1'b1;
    chk_en = 1;
    cur_req = "R10"; run(200);
    cur_req = "R4";
    wr('h00, 'h81); wr('h01, 'h01); wr('h02, 'h80); wr('h03, 'hA5); run(400);
    cur_req = "R3";
    wr('h01, 'h5A); wr('h02, 'h3C); run(200);
    cur_req = "R6";
    wr('h10, 'h33); wr('h11, 'hC3); wr('h18, 'h0F);
    wr('h05, 'h03); wr('h06, 'h01); wr('h07, 'hA0); run(200);
    cur_req = "R7";
    wr('h27, 'hE7); wr('h25, 'h6B); run(200);
    cur_req = "R5";
    wr('h04, 'h01); run(400);
    cur_req = "R8";
    wr('h08, 'hF0); wr('h09, 'h0F); wr('h0A, 'hAA); run(200);
    cur_req = "R9";
    wr('h04, 'h00); run(5);
    for (int i = 0; i < 12; i++) begin
      wr('h03, 16 * i + 3); run(i % 8);
      wr('h10 + i, 'hFF - 7 * i); run(3);
      wr('h00, 'h11 << (i % 4)); run(i % 5);
    end
    run(200);
    cur_req = "R11";
    wr('h0B, 'hFF); wr('h0C, 'hFF); wr('h0F, 'hFF); wr('h28, 'hFF); wr('h3F, 'hFF);
    run(200);
    cur_req = "R1";
    run(37); fcnt = 0; run(250); fcnt = 0; run(20);
    cur_req = "R2";
    wr('h00, 'hFF); wr('h01, 'hFF); wr('h02, 'hFF); run(400);
    @(negedge clk);
    chk_en = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule